// File: doc/BRIEF.md
# Dual-Bank Address-Pattern RAM Tester

This block runs a power-on style integrity test over two independent RAM banks through one shared memory port. Bank select, address, write data, write enable and a read strobe go out of the block; read data returns one clock after a read is issued. Bank 0 is tested completely before bank 1 is touched. Each bank gets two passes. A pass first fills every location and then reads every location back and compares it.

The first pass stores the low data-width bits of each location's own address. The second pass stores the bitwise inverse of those bits. Between them, the two passes catch bits stuck at either level, and the address-derived data exposes address lines that alias two locations. A single start pulse launches the sequence. A clean run ends with done and pass both high. On the first miscompare the block latches a one-hot failing-bank code, the failing address, and the expected and returned data. It then stops and keeps reading the failed location until reset, so the fault can be probed on the bus.

Top module: `dual_bank_ram_tester`

## Requirements
- R1: After reset, done, pass and failCode are 0 and no memory write or read is issued until start is pulsed.
- R2: Every access of bank 0 (memBank=0) comes before every access of bank 1 (memBank=1), and a failure in bank 0 ends the run with no access to bank 1.
- R3: Within a bank, the first pass writes addresses 0 to size-1 in ascending order. Each location receives the low DW bits of its address, zero-extended when the address is narrower than DW. No read of that bank happens before the write phase is complete.
- R4: After each write phase, every location of the bank is read once and compared with the value written to it. Read data is taken one clock after the read strobe.
- R5: If the first pass has no miscompare, a second pass follows with the same write-then-read order, using the bitwise complement of the low DW address bits.
- R6: failCode is 2'b01 for a bank 0 failure, 2'b10 for a bank 1 failure and 2'b00 otherwise.
- R7: failAddr, failExp and failGot hold the address, the expected data and the returned data of the first miscompare, and they do not change afterwards.
- R8: After a miscompare, the block issues a read of the failed bank and address on every clock, with no writes, and ignores start until reset. While in this state done=1 and pass=0.
- R9: When both banks finish both passes with no miscompare, done=1 and pass=1, and a later start pulse runs the full test again.
- R10: A start pulse while a test is running has no effect on the access sequence.
- R11: Bank 0 holds 2^BANK0_AW locations and bank 1 holds 2^BANK1_AW locations, and the two sizes may differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a test when idle or finished |
| done | output | 1 | Test has ended (clean or failed) |
| pass | output | 1 | Test ended with no miscompare |
| memBank | output | 1 | Bank select of the memory port |
| memAddr | output | AW | Location address (AW = larger bank width) |
| memRe | output | 1 | Read strobe; data returns next clock |
| memWe | output | 1 | Write enable |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data, one clock after memRe |
| failCode | output | 2 | One-hot failing bank code |
| failAddr | output | AW | Address of first miscompare |
| failExp | output | DW | Expected data at the miscompare |
| failGot | output | DW | Data returned at the miscompare |

## Verification
The bench builds the block with BANK0_AW=6, BANK1_AW=5 and DW=8. This gives banks of unequal size, and a whole clean run takes a few hundred clocks, so many faulted runs fit in one simulation. Because the addresses are narrower than the data, each address bit lands in the data pattern. A single stuck bit can therefore fail in either pass depending on its level, and an aliased address line fails at location 0 with a value the bench can predict. Stuck bits are placed at random banks, addresses, bit positions and levels, and directed cases cover the first and last locations, aliasing in the second bank, and start pulses during a run and after a failure.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN,
    ST_HANG,
    ST_DONE
  } rtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;     // new run: clear address, bank, pass and fail record
    logic clrAddr;    // wrap address to zero at end of a phase
    logic incAddr;    // step to next location
    logic doWrite;    // drive a write this cycle
    logic doRead;     // drive a read this cycle
    logic nextPass;   // move to complement pass
    logic nextBank;   // move to bank 1, first pass
    logic enterHang;  // latch failure and park on failed address
  } rtStrobe_t;

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      addrLast,
  input  logic      lastBank,
  input  logic      secondPass,
  input  logic      mismatch,
  output rtStrobe_t strb,
  output logic      done,
  output logic      pass
);

  rtState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strb.clrAll = 1'b1;
          stateD      = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strb.doWrite = 1'b1;
        if (addrLast) begin
          strb.clrAddr = 1'b1;
          stateD       = ST_READ;
        end else begin
          strb.incAddr = 1'b1;
        end
      end
      ST_READ: begin
        strb.doRead = 1'b1;
        if (mismatch) begin
          strb.enterHang = 1'b1;
          stateD         = ST_HANG;
        end else if (addrLast) begin
          strb.clrAddr = 1'b1;
          stateD       = ST_DRAIN;
        end else begin
          strb.incAddr = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (mismatch) begin
          strb.enterHang = 1'b1;
          stateD         = ST_HANG;
        end else if (!secondPass) begin
          strb.nextPass = 1'b1;
          stateD        = ST_WRITE;
        end else if (!lastBank) begin
          strb.nextBank = 1'b1;
          stateD        = ST_WRITE;
        end else begin
          stateD = ST_DONE;
        end
      end
      ST_HANG: begin
        strb.doRead = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign done = (stateQ == ST_DONE) || (stateQ == ST_HANG);
  assign pass = (stateQ == ST_DONE);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_WRITE || stateQ == ST_READ) && start) |=> (stateQ != ST_IDLE && stateQ != ST_DONE));

  // R8
  hang_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HANG) |=> (stateQ == ST_HANG));

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
#(
  parameter int BANK0_AW = 6,
  parameter int BANK1_AW = 5,
  parameter int DW       = 8,
  localparam int AW      = (BANK0_AW > BANK1_AW) ? BANK0_AW : BANK1_AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  rtStrobe_t     strb,
  output logic          addrLast,
  output logic          lastBank,
  output logic          secondPass,
  output logic          mismatch,
  output logic          memBank,
  output logic [AW-1:0] memAddr,
  output logic          memRe,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic [1:0]    failCode,
  output logic [AW-1:0] failAddr,
  output logic [DW-1:0] failExp,
  output logic [DW-1:0] failGot
);

  localparam logic [AW-1:0] LAST0 = AW'((64'd1 << BANK0_AW) - 64'd1);
  localparam logic [AW-1:0] LAST1 = AW'((64'd1 << BANK1_AW) - 64'd1);

  logic [AW-1:0] addrQ, addrPipeQ;
  logic          bankQ, secondQ, rdValidQ;
  logic [DW-1:0] pattern, expQ;
  logic [1:0]    failCodeQ;
  logic [AW-1:0] failAddrQ;
  logic [DW-1:0] failExpQ, failGotQ;

  // address-derived pattern, inverted on the second pass
  assign pattern = secondQ ? ~DW'(addrQ) : DW'(addrQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      bankQ   <= 1'b0;
      secondQ <= 1'b0;
    end else begin
      if (strb.clrAll || strb.clrAddr) addrQ <= '0;
      else if (strb.enterHang)         addrQ <= addrPipeQ;
      else if (strb.incAddr)           addrQ <= addrQ + 1'b1;

      if (strb.clrAll)        bankQ <= 1'b0;
      else if (strb.nextBank) bankQ <= 1'b1;

      if (strb.clrAll || strb.nextBank) secondQ <= 1'b0;
      else if (strb.nextPass)           secondQ <= 1'b1;
    end
  end

  // one-cycle read latency: carry expected value alongside the read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ  <= 1'b0;
      expQ      <= '0;
      addrPipeQ <= '0;
    end else begin
      rdValidQ  <= strb.doRead;
      expQ      <= pattern;
      addrPipeQ <= addrQ;
    end
  end

  assign mismatch = rdValidQ && (memRdata != expQ);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      failCodeQ <= 2'b00;
      failAddrQ <= '0;
      failExpQ  <= '0;
      failGotQ  <= '0;
    end else if (strb.enterHang) begin
      failCodeQ <= bankQ ? 2'b10 : 2'b01;
      failAddrQ <= addrPipeQ;
      failExpQ  <= expQ;
      failGotQ  <= memRdata;
    end
  end

  assign addrLast   = (addrQ == (bankQ ? LAST1 : LAST0));
  assign lastBank   = bankQ;
  assign secondPass = secondQ;

  assign memBank  = bankQ;
  assign memAddr  = addrQ;
  assign memRe    = strb.doRead;
  assign memWe    = strb.doWrite;
  assign memWdata = pattern;

  assign failCode = failCodeQ;
  assign failAddr = failAddrQ;
  assign failExp  = failExpQ;
  assign failGot  = failGotQ;

  // R2
  bank_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankQ && !strb.clrAll) |=> bankQ);

  // R3
  write_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (addrQ == $past(addrQ) + 1'b1));

  // R6
  fail_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(failCodeQ));

  // R7
  fail_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failCodeQ != 2'b00) |=> ($stable(failAddrQ) && $stable(failExpQ) && $stable(failGotQ)));

  // R8
  hang_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failCodeQ != 2'b00) |=> (memRe && !memWe && $stable(memAddr) && $stable(memBank)));

endmodule

// File: rtl/dual_bank_ram_tester.sv
module dual_bank_ram_tester
  import rt_pkg::*;
#(
  parameter int BANK0_AW = 6,
  parameter int BANK1_AW = 5,
  parameter int DW       = 8,
  localparam int AW      = (BANK0_AW > BANK1_AW) ? BANK0_AW : BANK1_AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          done,
  output logic          pass,
  output logic          memBank,
  output logic [AW-1:0] memAddr,
  output logic          memRe,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic [1:0]    failCode,
  output logic [AW-1:0] failAddr,
  output logic [DW-1:0] failExp,
  output logic [DW-1:0] failGot
);

  rtStrobe_t strb;
  logic      addrLast, lastBank, secondPass, mismatch;

  rt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .addrLast   (addrLast),
    .lastBank   (lastBank),
    .secondPass (secondPass),
    .mismatch   (mismatch),
    .strb       (strb),
    .done       (done),
    .pass       (pass)
  );

  rt_datapath #(
    .BANK0_AW (BANK0_AW),
    .BANK1_AW (BANK1_AW),
    .DW       (DW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addrLast   (addrLast),
    .lastBank   (lastBank),
    .secondPass (secondPass),
    .mismatch   (mismatch),
    .memBank    (memBank),
    .memAddr    (memAddr),
    .memRe      (memRe),
    .memWe      (memWe),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .failCode   (failCode),
    .failAddr   (failAddr),
    .failExp    (failExp),
    .failGot    (failGot)
  );

  // R9
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (done && failCode == 2'b00));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !memWe && !memRe && $past(!rstN)) |-> (failCode == 2'b00));

endmodule

// File: tb/sim_dual_bank_ram_tester.sv
module sim_dual_bank_ram_tester;

  localparam int B0 = 6;
  localparam int B1 = 5;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int SZ0 = 1 << B0;
  localparam int SZ1 = 1 << B1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          done, pass, memBank, memRe, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic [1:0]    failCode;
  logic [AW-1:0] failAddr;
  logic [DW-1:0] failExp, failGot;

  always #2.5 clk = ~clk;

  dual_bank_ram_tester #(.BANK0_AW(B0), .BANK1_AW(B1), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .pass(pass),
    .memBank(memBank), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .failCode(failCode),
    .failAddr(failAddr), .failExp(failExp), .failGot(failGot)
  );

  // fault model: 0 none, 1 stuck data bit, 2 aliased address bit
  int faultKind = 0, faultBank = 0, faultAddr = 0, faultBit = 0, faultVal = 0;

  logic [DW-1:0] mem0 [SZ0];
  logic [DW-1:0] mem1 [SZ1];

  function automatic int effAddr(int bk, int a);
    if (faultKind == 2 && bk == faultBank) return a & ~(1 << faultBit);
    return a;
  endfunction

  always @(posedge clk) begin
    int ea;
    logic [DW-1:0] d;
    ea = effAddr(int'(memBank), int'(memAddr));
    if (memWe) begin
      d = memWdata;
      if (faultKind == 1 && int'(memBank) == faultBank && ea == faultAddr) d[faultBit] = faultVal[0];
      if (memBank) mem1[ea % SZ1] <= d;
      else         mem0[ea % SZ0] <= d;
    end
    memRdata <= memBank ? mem1[ea % SZ1] : mem0[ea % SZ0];
  end

  // access monitor
  int  wr0 = 0, wr1 = 0, orderErr = 0, seqErr = 0, wdErr = 0, rd0 = 0, rd1 = 0;
  bit  seen1 = 1'b0;
  bit  clrMon = 1'b0;

  always @(posedge clk) begin
    int cnt, sz, a, p;
    if (clrMon) begin
      wr0 = 0; wr1 = 0; orderErr = 0; seqErr = 0; wdErr = 0; rd0 = 0; rd1 = 0; seen1 = 1'b0;
    end else if (rstN) begin
      if (memWe || memRe) begin
        if (memBank) seen1 = 1'b1;
        else if (seen1) orderErr++;
      end
      cnt = memBank ? wr1 : wr0;
      sz  = memBank ? SZ1 : SZ0;
      if (memWe) begin
        a = cnt % sz;
        p = cnt / sz;
        if (p > 1 || int'(memAddr) != a ||
            memWdata != ((p == 1) ? ~DW'(a) : DW'(a))) wdErr++;
        if (memBank) wr1++; else wr0++;
      end
      if (memRe) begin
        if (cnt == 0 || (cnt % sz) != 0) seqErr++;
        if (memBank) rd1++; else rd0++;
      end
    end
  end

  int nChecks = 0, nFails = 0;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitDone(int midStartAt);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i == midStartAt) start = 1'b1;
      else start = 1'b0;
      if (done) break;
    end
    start = 1'b0;
  endtask

  // kind 0 clean, 1 stuck, 2 alias
  task automatic runOne(int kind, int bk, int ad, int bt, int vl, int midStartAt);
    int p1, eAddr, eExp, eGot;
    faultKind = kind; faultBank = bk; faultAddr = ad; faultBit = bt; faultVal = vl;
    doReset();
    clrMon = 1'b1;
    @(negedge clk);
    clrMon = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(midStartAt);
    chk("R9 done", int'(done), 1);
    if (kind == 0) begin
      chk("R9 pass", int'(pass), 1);
      chk("R6 code clean", int'(failCode), 0);
      chk("R11 bank0 writes", wr0, 2 * SZ0);
      chk("R11 bank1 writes", wr1, 2 * SZ1);
      chk("R4 bank0 reads", rd0, 2 * SZ0);
      chk("R4 bank1 reads", rd1, 2 * SZ1);
      chk("R2 order", orderErr, 0);
      chk("R3 R5 write data", wdErr, 0);
      chk("R3 read after fill", seqErr, 0);
      if (midStartAt >= 0) chk("R10 no restart", wr0 + wr1, 2 * (SZ0 + SZ1));
    end else begin
      if (kind == 2) begin
        eAddr = 0; eExp = 0; eGot = (1 << bt) & 255;
      end else begin
        p1 = ad & 255;
        eAddr = ad;
        if (((p1 >> bt) & 1) != vl) begin
          eExp = p1;
        end else begin
          eExp = (~p1) & 255;
        end
        eGot = vl ? (eExp | (1 << bt)) : (eExp & ~(1 << bt));
      end
      chk("R8 pass low", int'(pass), 0);
      chk("R6 code", int'(failCode), bk ? 2 : 1);
      chk("R7 addr", int'(failAddr), eAddr);
      chk("R7 exp", int'(failExp), eExp);
      chk("R7 got", int'(failGot), eGot);
      chk("R3 R5 write data", wdErr, 0);
      chk("R4 read after fill", seqErr, 0);
      if (bk == 0) chk("R2 bank1 untouched", wr1 + rd1, 0);
      else         chk("R2 bank0 complete", wr0, 2 * SZ0);
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk("R8 hang read", int'(memRe), 1);
        chk("R8 hang no write", int'(memWe), 0);
        chk("R8 hang addr", int'(memAddr), eAddr);
        chk("R8 hang bank", int'(memBank), bk);
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 start ignored code", int'(failCode), bk ? 2 : 1);
      chk("R8 start ignored addr", int'(memAddr), eAddr);
      chk("R8 start ignored we", int'(memWe), 0);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nFails++;
        $display("FAIL R9: watchdog expired, actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    int bk, ad, bt, vl;
    void'($urandom(32'd24681));
    doReset();
    clrMon = 1'b1;
    @(negedge clk);
    clrMon = 1'b0;
    repeat (8) @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 pass", int'(pass), 0);
    chk("R1 code", int'(failCode), 0);
    chk("R1 no access", wr0 + wr1 + rd0 + rd1, 0);

    runOne(0, 0, 0, 0, 0, -1);
    // R9 rerun after clean finish
    clrMon = 1'b1;
    @(negedge clk);
    clrMon = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9 rerun busy", int'(done), 0);
    waitDone(-1);
    chk("R9 rerun pass", int'(pass), 1);
    chk("R9 rerun writes", wr0 + wr1, 2 * (SZ0 + SZ1));

    runOne(0, 0, 0, 0, 0, 40);              // R10 start mid-run
    runOne(1, 0, 0, 0, 1, -1);              // bank0 addr 0, fails pass 1
    runOne(1, 0, SZ0 - 1, 3, 1, -1);        // last location, bit matches pass 1 -> pass 2 fail
    runOne(1, 1, SZ1 - 1, 7, 0, -1);        // bank1 last, upper bit stuck low
    runOne(2, 1, 0, 2, 0, -1);              // alias in bank1
    runOne(2, 0, 0, 5, 0, -1);              // alias in bank0 top address line
    for (int k = 0; k < 10; k++) begin
      bk = int'($urandom % 2);
      ad = int'($urandom % (bk ? SZ1 : SZ0));
      bt = int'($urandom % DW);
      vl = int'($urandom % 2);
      runOne(1, bk, ad, bt, vl, -1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule